// File: doc/BRIEF.md
# UART Channel Mode and FIFO Router

This block sits between a UART's serial receiver, its serial transmitter and the host data register. It holds the receive and transmit FIFOs and steers each byte to the right one according to a two-bit channel mode. The modes are normal, automatic echo, local loopback and remote loopback. It also holds the control register, which carries the enable and disable bits for each direction and the self-clearing FIFO flush bits.

Bytes from the line enter the block with a valid flag, and a line break counts as a zero byte. The block returns a ready signal to the line, which drops whenever a FIFO that the current mode writes into has no free space. The transmitter pulls bytes from the TX FIFO through a valid/ready pair. The host writes and reads the data register through strobes, and a read returns its byte in the same cycle.

Two one-cycle events come out of the block. The overrun event flags a byte that was lost. The timeout event fires when the receive line has been quiet for a set number of character times, counted on a tick supplied by the baud logic.

Top module: `uart_chan_router`

## Requirements
- R1: `mode_i` selects the channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. In modes 0 and 1, a line byte is pushed into the RX FIFO.
- R2: In modes 1 and 3, a line byte is pushed into the TX FIFO. In mode 1 the same byte also goes to the RX FIFO.
- R3: A host data write goes to the TX FIFO in mode 0 and to the RX FIFO in mode 2. In modes 1 and 3 it is ignored.
- R4: The receiver is active only while control bit 2 is 1 and control bit 3 is 0. The transmitter is active only while control bit 4 is 1 and control bit 5 is 0. An inactive side accepts no pushes.
- R5: After reset, `ctrl_o` reads 0x128. A control write that sets bit 0 (RX) or bit 1 (TX) keeps that bit visible for one cycle. On the next edge the bit clears and the FIFO empties. A push in that same cycle is lost.
- R6: A push that meets a full FIFO drops the byte, and `ovr_o` pulses for one cycle in the following cycle.
- R7: A host read returns the oldest RX byte and pops it. If the RX FIFO is empty, or the receiver is inactive, the read returns 0 and the FIFO is left unchanged.
- R8: `line_ready_o` is low whenever a FIFO that the current mode fills from the line is full.
- R9: A break pulse on `line_break_i` enters the FIFOs as the byte 0x00, in place of `line_data_i`.
- R10: Each accepted RX push restarts the timer. After 4 character ticks with no push, `timeout_o` pulses once, on the cycle after the fourth tick, provided `timeout_val_i` is nonzero. It then stays silent until the next push. When a push and a tick fall in the same cycle, the push wins.
- R11: `tx_valid_o` is high while the TX FIFO holds data. A byte leaves on each cycle with `tx_ready_i` high, in the order the bytes were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Channel mode |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 9 | Control register write value |
| ctrl_o | output | 9 | Control register value |
| timeout_val_i | input | TW | Timeout setting; zero disables the event |
| char_tick_i | input | 1 | One pulse per character time |
| line_valid_i | input | 1 | Received byte valid |
| line_break_i | input | 1 | Received break condition |
| line_data_i | input | W | Received byte |
| line_ready_o | output | 1 | Room for a line byte |
| host_wr_i | input | 1 | Host data register write |
| host_wdata_i | input | W | Host write byte |
| host_rd_i | input | 1 | Host data register read |
| host_rdata_o | output | W | Host read byte, same cycle |
| tx_valid_o | output | 1 | TX FIFO holds a byte |
| tx_data_o | output | W | Oldest TX byte |
| tx_ready_i | input | 1 | Transmitter takes the byte |
| ovr_o | output | 1 | Overrun event pulse |
| timeout_o | output | 1 | Receive timeout event pulse |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a FIFO flush and a push. The bench provokes it by sending a line byte in the cycle right after a control write that sets the RX flush bit. It judges the outcome by the next host read, which must return 0.

The second pair is the timeout tick and a new receive byte. The bench drives both in one cycle after three ticks have already passed. The event must then stay silent for three more ticks and fire on the fourth. The remaining checks sweep all four modes with one line byte and one host write each, and check the contents of both FIFOs against a routing table computed in the bench.

// File: rtl/uart_rt_pkg.sv
package uart_rt_pkg;
  typedef enum logic [1:0] {
    CM_NORMAL = 2'd0,
    CM_ECHO   = 2'd1,
    CM_LOCAL  = 2'd2,
    CM_REMOTE = 2'd3
  } chan_mode_e;

  localparam int CTRL_W = 9;
  localparam logic [CTRL_W-1:0] CTRL_RST = 9'h128;
  localparam int CB_RX_FLUSH = 0;
  localparam int CB_TX_FLUSH = 1;
  localparam int CB_RX_EN    = 2;
  localparam int CB_RX_DIS   = 3;
  localparam int CB_TX_EN    = 4;
  localparam int CB_TX_DIS   = 5;

  function automatic logic line_feeds_rx(input logic [1:0] m);
    return (m == CM_NORMAL) || (m == CM_ECHO);
  endfunction

  function automatic logic line_feeds_tx(input logic [1:0] m);
    return (m == CM_ECHO) || (m == CM_REMOTE);
  endfunction
endpackage

// File: rtl/uart_rt_fifo.sv
module uart_rt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem[rptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush_i) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wptr] <= wdata_i;
  end
endmodule

// File: rtl/uart_rt_route.sv
module uart_rt_route
  import uart_rt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   mode_i,
  input  logic         rx_act_i,
  input  logic         tx_act_i,
  input  logic         line_valid_i,
  input  logic         line_break_i,
  input  logic [W-1:0] line_data_i,
  input  logic         host_wr_i,
  input  logic [W-1:0] host_wdata_i,
  input  logic         rx_full_i,
  input  logic         tx_full_i,
  output logic         rx_push_o,
  output logic [W-1:0] rx_wdata_o,
  output logic         tx_push_o,
  output logic [W-1:0] tx_wdata_o,
  output logic         rx_accept_o,
  output logic         line_ready_o,
  output logic         ovr_o
);
  logic         byte_v, to_rx, to_tx, host_tx, host_rx;
  logic [W-1:0] byte_d;

  // break is a zero byte on the normal path
  assign byte_v  = line_valid_i | line_break_i;
  assign byte_d  = line_break_i ? '0 : line_data_i;
  assign to_rx   = line_feeds_rx(mode_i);
  assign to_tx   = line_feeds_tx(mode_i);
  assign host_tx = host_wr_i & (mode_i == CM_NORMAL);
  assign host_rx = host_wr_i & (mode_i == CM_LOCAL);

  assign rx_push_o  = rx_act_i & ((byte_v & to_rx) | host_rx);
  assign rx_wdata_o = host_rx ? host_wdata_i : byte_d;
  assign tx_push_o  = tx_act_i & ((byte_v & to_tx) | host_tx);
  assign tx_wdata_o = host_tx ? host_wdata_i : byte_d;

  assign rx_accept_o  = rx_push_o & ~rx_full_i;
  assign ovr_o        = (rx_push_o & rx_full_i) | (tx_push_o & tx_full_i);
  assign line_ready_o = ~(to_rx & rx_full_i) & ~(to_tx & tx_full_i);
endmodule

// File: rtl/uart_rt_timeout.sv
module uart_rt_timeout #(
  parameter int TO_CHARS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  input  logic enable_i,
  output logic fire_o
);
  localparam int CW = $clog2(TO_CHARS + 1);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      armed  <= 1'b0;
      fire_o <= 1'b0;
    end else if (restart_i) begin
      cnt    <= '0;
      armed  <= 1'b1;
      fire_o <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (armed && tick_i) begin
        if (cnt == CW'(TO_CHARS - 1)) begin
          armed  <= 1'b0;
          fire_o <= enable_i;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
  import uart_rt_pkg::*;
#(
  parameter int W        = 8,
  parameter int RX_DEPTH = 8,
  parameter int TX_DEPTH = 8,
  parameter int TO_CHARS = 4,
  parameter int TW       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic [TW-1:0]     timeout_val_i,
  input  logic              char_tick_i,
  input  logic              line_valid_i,
  input  logic              line_break_i,
  input  logic [W-1:0]      line_data_i,
  output logic              line_ready_o,
  input  logic              host_wr_i,
  input  logic [W-1:0]      host_wdata_i,
  input  logic              host_rd_i,
  output logic [W-1:0]      host_rdata_o,
  output logic              tx_valid_o,
  output logic [W-1:0]      tx_data_o,
  input  logic              tx_ready_i,
  output logic              ovr_o,
  output logic              timeout_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              rx_act, tx_act;
  logic              rx_push, tx_push, rx_accept, ovr_raw;
  logic [W-1:0]      rx_wdata, tx_wdata, rx_head;
  logic              rx_full, rx_empty, tx_full, tx_empty;
  logic              rd_ok;

  // flush bits stay visible for one cycle, then act and clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (ctrl_wr_i) begin
      ctrl_q <= ctrl_wdata_i;
    end else begin
      ctrl_q[CB_RX_FLUSH] <= 1'b0;
      ctrl_q[CB_TX_FLUSH] <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign rx_act = ctrl_q[CB_RX_EN] & ~ctrl_q[CB_RX_DIS];
  assign tx_act = ctrl_q[CB_TX_EN] & ~ctrl_q[CB_TX_DIS];

  uart_rt_route #(.W(W)) u_route (
    .mode_i       (mode_i),
    .rx_act_i     (rx_act),
    .tx_act_i     (tx_act),
    .line_valid_i (line_valid_i),
    .line_break_i (line_break_i),
    .line_data_i  (line_data_i),
    .host_wr_i    (host_wr_i),
    .host_wdata_i (host_wdata_i),
    .rx_full_i    (rx_full),
    .tx_full_i    (tx_full),
    .rx_push_o    (rx_push),
    .rx_wdata_o   (rx_wdata),
    .tx_push_o    (tx_push),
    .tx_wdata_o   (tx_wdata),
    .rx_accept_o  (rx_accept),
    .line_ready_o (line_ready_o),
    .ovr_o        (ovr_raw)
  );

  assign rd_ok        = host_rd_i & rx_act & ~rx_empty;
  assign host_rdata_o = rd_ok ? rx_head : '0;

  uart_rt_fifo #(.W(W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (ctrl_q[CB_RX_FLUSH]),
    .push_i  (rx_push),
    .wdata_i (rx_wdata),
    .pop_i   (rd_ok),
    .rdata_o (rx_head),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  assign tx_valid_o = ~tx_empty;

  uart_rt_fifo #(.W(W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (ctrl_q[CB_TX_FLUSH]),
    .push_i  (tx_push),
    .wdata_i (tx_wdata),
    .pop_i   (tx_ready_i & tx_valid_o),
    .rdata_o (tx_data_o),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  uart_rt_timeout #(.TO_CHARS(TO_CHARS)) u_timeout (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (rx_accept),
    .tick_i    (char_tick_i),
    .enable_i  (timeout_val_i != '0),
    .fire_o    (timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_o <= 1'b0;
    else         ovr_o <= ovr_raw;
  end
endmodule

// File: rtl/uart_chan_router_chk.sv
module uart_chan_router_chk #(
  parameter int W  = 8,
  parameter int TW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          line_ready_o,
  input logic          host_rd_i,
  input logic [W-1:0]  host_rdata_o,
  input logic          ctrl_wr_i,
  input logic [8:0]    ctrl_q,
  input logic [TW-1:0] timeout_val_i,
  input logic          timeout_o,
  input logic          ovr_o,
  input logic          rx_full,
  input logic          tx_full,
  input logic          rx_empty,
  input logic          rx_push
);
  p_ready_rx_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'd0 || mode_i == 2'd1) && rx_full) |-> !line_ready_o);

  p_ready_tx_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'd1 || mode_i == 2'd3) && tx_full) |-> !line_ready_o);

  p_rd_empty_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && rx_empty) |-> (host_rdata_o == '0));

  p_flush_selfclear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[0] && !ctrl_wr_i) |=> !ctrl_q[0]);

  p_rx_push_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push |-> (ctrl_q[2] && !ctrl_q[3]));

  p_timeout_enabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $past(timeout_val_i != '0));

  p_ovr_needs_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> $past(rx_full || tx_full));
endmodule

bind uart_chan_router uart_chan_router_chk #(.W(W), .TW(TW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_i        (mode_i),
  .line_ready_o  (line_ready_o),
  .host_rd_i     (host_rd_i),
  .host_rdata_o  (host_rdata_o),
  .ctrl_wr_i     (ctrl_wr_i),
  .ctrl_q        (ctrl_q),
  .timeout_val_i (timeout_val_i),
  .timeout_o     (timeout_o),
  .ovr_o         (ovr_o),
  .rx_full       (rx_full),
  .tx_full       (tx_full),
  .rx_empty      (rx_empty),
  .rx_push       (rx_push)
);

// File: tb/uart_chan_router_tb_top.sv
module uart_chan_router_tb_top;
  localparam int DEPTH = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       ctrl_wr_i = 1'b0;
  logic [8:0] ctrl_wdata_i = '0;
  logic [8:0] ctrl_o;
  logic [7:0] timeout_val_i = 8'd5;
  logic       char_tick_i = 1'b0;
  logic       line_valid_i = 1'b0;
  logic       line_break_i = 1'b0;
  logic [7:0] line_data_i = '0;
  logic       line_ready_o;
  logic       host_wr_i = 1'b0;
  logic [7:0] host_wdata_i = '0;
  logic       host_rd_i = 1'b0;
  logic [7:0] host_rdata_o;
  logic       tx_valid_o;
  logic [7:0] tx_data_o;
  logic       tx_ready_i = 1'b0;
  logic       ovr_o;
  logic       timeout_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  uart_chan_router #(.RX_DEPTH(DEPTH), .TX_DEPTH(DEPTH)) dut_i (
    .clk_i, .rst_ni, .mode_i, .ctrl_wr_i, .ctrl_wdata_i, .ctrl_o,
    .timeout_val_i, .char_tick_i, .line_valid_i, .line_break_i,
    .line_data_i, .line_ready_o, .host_wr_i, .host_wdata_i, .host_rd_i,
    .host_rdata_o, .tx_valid_o, .tx_data_o, .tx_ready_i, .ovr_o, .timeout_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // all tasks start and end at a falling edge
  task automatic ctrl_write(input logic [8:0] v);
    ctrl_wr_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i);
    ctrl_wr_i = 1'b0;
  endtask

  task automatic flush_all();
    ctrl_write(9'h017);
    chk(ctrl_o[1:0] == 2'b11, "R5 flush bits visible", int'(ctrl_o[1:0]), 3);
    @(negedge clk_i);
    chk(ctrl_o[1:0] == 2'b00, "R5 flush bits cleared", int'(ctrl_o[1:0]), 0);
  endtask

  task automatic line_send(input logic [7:0] d, input bit brk, input bit tk, output bit ovr);
    line_valid_i = ~brk; line_break_i = brk; line_data_i = d; char_tick_i = tk;
    @(negedge clk_i);
    ovr = ovr_o;
    line_valid_i = 1'b0; line_break_i = 1'b0; char_tick_i = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] d);
    host_wr_i = 1'b1; host_wdata_i = d;
    @(negedge clk_i);
    host_wr_i = 1'b0;
  endtask

  task automatic host_read(output logic [7:0] d);
    host_rd_i = 1'b1;
    #1 d = host_rdata_o;
    @(negedge clk_i);
    host_rd_i = 1'b0;
  endtask

  task automatic tx_take(output logic [7:0] d, output bit v);
    v = tx_valid_o; d = tx_data_o;
    if (v) tx_ready_i = 1'b1;
    @(negedge clk_i);
    tx_ready_i = 1'b0;
  endtask

  task automatic tick(output bit fired);
    char_tick_i = 1'b1;
    @(negedge clk_i);
    fired = timeout_o;
    char_tick_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    bit v, o, f;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    chk(ctrl_o == 9'h128, "R5 reset ctrl", int'(ctrl_o), 'h128);
    chk(tx_valid_o == 1'b0, "R11 reset tx empty", int'(tx_valid_o), 0);
    chk(line_ready_o == 1'b1, "R8 reset ready", int'(line_ready_o), 1);
    chk(ovr_o == 1'b0 && timeout_o == 1'b0, "R6 reset events", int'({ovr_o, timeout_o}), 0);

    // receiver disabled after reset: byte dropped
    line_send(8'h44, 0, 0, o);
    ctrl_write(9'h014);
    host_read(d);
    chk(d == 8'h00, "R4 byte dropped while rx off", int'(d), 0);

    // mode sweep: one line byte then one host write per mode
    for (int m = 0; m < 4; m++) begin
      logic [7:0] a, b;
      logic [7:0] exp_rx[2], exp_tx[2];
      int n_rx, n_tx;
      a = 8'h30 + 8'(m); b = 8'h50 + 8'(m);
      n_rx = 0; n_tx = 0;
      if (m == 0 || m == 1) begin exp_rx[n_rx] = a; n_rx++; end
      if (m == 2)           begin exp_rx[n_rx] = b; n_rx++; end
      if (m == 1 || m == 3) begin exp_tx[n_tx] = a; n_tx++; end
      if (m == 0)           begin exp_tx[n_tx] = b; n_tx++; end
      mode_i = 2'(m);
      flush_all();
      line_send(a, 0, 0, o);
      host_write(b);
      for (int i = 0; i <= n_rx; i++) begin
        host_read(d);
        if (i < n_rx) chk(d == exp_rx[i], "R1 R3 rx routing", int'(d), int'(exp_rx[i]));
        else          chk(d == 8'h00, "R3 R7 rx extra empty", int'(d), 0);
      end
      for (int i = 0; i <= n_tx; i++) begin
        tx_take(d, v);
        if (i < n_tx) chk(v && d == exp_tx[i], "R2 R3 tx routing", int'({v, d}), int'({1'b1, exp_tx[i]}));
        else          chk(!v, "R2 tx extra empty", int'(v), 0);
      end
    end

    // read while rx inactive leaves fifo alone
    mode_i = 2'd0;
    flush_all();
    line_send(8'h77, 0, 0, o);
    ctrl_write(9'h01C);
    host_read(d);
    chk(d == 8'h00, "R7 read while rx off", int'(d), 0);
    line_send(8'h78, 0, 0, o);
    ctrl_write(9'h014);
    host_read(d);
    chk(d == 8'h77, "R7 fifo kept", int'(d), 'h77);
    host_read(d);
    chk(d == 8'h00, "R4 rx off byte dropped", int'(d), 0);

    // transmitter inactive
    ctrl_write(9'h034);
    host_write(8'h99);
    chk(!tx_valid_o, "R4 tx off ignores write", int'(tx_valid_o), 0);
    ctrl_write(9'h014);
    chk(!tx_valid_o, "R4 tx still empty", int'(tx_valid_o), 0);

    // rx overrun
    flush_all();
    for (int i = 0; i < DEPTH; i++) begin
      line_send(8'(i * 3 + 1), 0, 0, o);
      chk(!o, "R6 no overrun before full", int'(o), 0);
    end
    chk(!line_ready_o, "R8 ready low rx full", int'(line_ready_o), 0);
    line_send(8'hEE, 0, 0, o);
    chk(o, "R6 overrun pulse", int'(o), 1);
    for (int i = 0; i <= DEPTH; i++) begin
      host_read(d);
      if (i == 0) chk(!ovr_o, "R6 pulse one cycle", int'(ovr_o), 0);
      if (i < DEPTH) chk(d == 8'(i * 3 + 1), "R6 kept bytes", int'(d), i * 3 + 1);
      else           chk(d == 8'h00, "R6 dropped byte absent", int'(d), 0);
    end

    // remote loopback back-pressure and tx order
    flush_all();
    mode_i = 2'd3;
    for (int i = 0; i < DEPTH; i++) line_send(8'(8'hA0 + i), 0, 0, o);
    chk(!line_ready_o, "R8 ready low tx full", int'(line_ready_o), 0);
    mode_i = 2'd0;
    #1 chk(line_ready_o, "R8 ready in normal with tx full", int'(line_ready_o), 1);
    host_read(d);
    chk(d == 8'h00, "R2 remote mode rx untouched", int'(d), 0);
    for (int i = 0; i < DEPTH; i++) begin
      tx_take(d, v);
      chk(v && d == 8'(8'hA0 + i), "R11 tx order", int'(d), 'hA0 + i);
    end

    // break enters as zero
    flush_all();
    line_send(8'h55, 1, 0, o);
    line_send(8'h22, 0, 0, o);
    host_read(d);
    chk(d == 8'h00, "R9 break byte", int'(d), 0);
    host_read(d);
    chk(d == 8'h22, "R9 after break", int'(d), 'h22);

    // flush wins over same-cycle push
    line_send(8'h11, 0, 0, o);
    ctrl_write(9'h015);
    line_send(8'h66, 0, 0, o);
    host_read(d);
    chk(d == 8'h00, "R5 flush beats push", int'(d), 0);

    // timeout
    timeout_val_i = 8'd5;
    line_send(8'h01, 0, 0, o);
    for (int k = 1; k <= 5; k++) begin
      tick(f);
      chk(f == (k == 4), "R10 timeout after four ticks", int'(f), int'(k == 4));
    end
    line_send(8'h02, 0, 0, o);
    for (int k = 0; k < 3; k++) begin
      tick(f);
      chk(!f, "R10 early tick", int'(f), 0);
    end
    line_send(8'h03, 0, 1, o);
    chk(!timeout_o, "R10 byte beats tick", int'(timeout_o), 0);
    for (int k = 1; k <= 4; k++) begin
      tick(f);
      chk(f == (k == 4), "R10 restart count", int'(f), int'(k == 4));
    end
    timeout_val_i = 8'd0;
    line_send(8'h04, 0, 0, o);
    for (int k = 0; k < 5; k++) begin
      tick(f);
      chk(!f, "R10 zero setting silent", int'(f), 0);
    end

    done = 1;
    finish_run();
  end
endmodule